// File: doc/BRIEF.md
# Dual-Slot Card Access Controller

This block lets a host reach two removable conditional-access cards through one small byte-wide register file. The host loads a 14-bit card address into two address registers. It then picks the target slot and the address space (attribute memory, or the control/IO space) in a bus-control register. A single write or read of the data register then runs a complete card cycle. The block drives the card strobe for a fixed number of clocks, latches the read byte and returns it to the host.

The same register file also handles slot housekeeping. Each slot has a reset that software requests and hardware ends: the request bit stays set while the reset runs and clears itself when the reset is over. Each slot also has a transport-stream routing enable and a card-detect flag that reads low when a card is present. A change of either card-detect input raises an interrupt, which a read of the interrupt register acknowledges. A second control register drives two stream-output enables and two active-low tuner resets.

Top module: `ca_slot_ctrl`

## Requirements
- R1: Register 0x4 keeps write bits 7:1 and always reads bit 0 as 0. Register 0x5 keeps write bits 6:0 and reads bit 7 as 0. During a card cycle, card_addr_o equals {reg5[6:0], reg4[7:1], 1'b0}.
- R2: Bus-control register 0x7, bit 7, selects the slot: 0 asserts card_sel_o[0] and 1 asserts card_sel_o[1]. Bit 6 sets card_iosp_o (1 = control/IO space, 0 = attribute memory). card_sel_o is all zero outside a strobe.
- R3: A host write to data register 0x6 drives card_wr_o high for exactly STROBE_CYCLES clocks, with card_wdata_o equal to the written byte.
- R4: A host read of register 0x6 drives card_rd_o high for exactly STROBE_CYCLES clocks. The block then returns card_rdata_i, as sampled in the last strobe clock, on reg_rdata_o together with a reg_rvalid_o pulse.
- R5: A read of any other register returns its value with reg_rvalid_o exactly one clock after reg_re_i.
- R6: Writing 1 to register 0x7 bit 5 (slot 0) or bit 4 (slot 1) sets that bit and holds card_rst_o[slot] high for RST_CYCLES clocks, after which the bit reads 0 again. Writing 0 to these bits has no effect.
- R7: Register 0x7 bit 3 drives ts_en_o[0] and bit 2 drives ts_en_o[1]. Both bits read back as written.
- R8: Register 0x7 bit 1 reads card_cd_n_i[0] and bit 0 reads card_cd_n_i[1], each after a two-flop synchronizer. Writes to these bits are ignored.
- R9: Interrupt register 0x0 keeps write bits 7:1. Bit 6 enables change interrupts for slot 0 and bit 2 for slot 1. A change of an enabled synchronized card-detect sets the pending flag (read bit 0), which drives irq_n_o low. A read of register 0x0 clears the flag, unless a new enabled change arrives in the same clock.
- R10: Register 0x1 resets to 0x0C. Bits 5:4 drive ts_out_en_o[1:0]. Bit 3 drives tuner_rst_n_o[0] and bit 2 drives tuner_rst_n_o[1].
- R11: While a card cycle runs, cyc_busy_o is high and further data-register accesses are ignored: the strobe length and the write data do not change.
- R12: After reset, irq_n_o is high, tuner_rst_n_o is 2'b11, and card_rd_o, card_wr_o, card_rst_o, ts_en_o and ts_out_en_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 4 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_rdata_o | output | 8 | Read data |
| reg_rvalid_o | output | 1 | Read data valid |
| cyc_busy_o | output | 1 | Card cycle in progress |
| card_addr_o | output | 15 | Card byte address |
| card_sel_o | output | 2 | Per-slot select during a strobe |
| card_iosp_o | output | 1 | 1 = control/IO space, 0 = attribute memory |
| card_rd_o | output | 1 | Card read strobe |
| card_wr_o | output | 1 | Card write strobe |
| card_wdata_o | output | 8 | Card write data |
| card_rdata_i | input | 8 | Card read data |
| card_rst_o | output | 2 | Per-slot card reset |
| card_cd_n_i | input | 2 | Per-slot card detect, low = present |
| ts_en_o | output | 2 | Per-slot transport-stream routing enable |
| irq_n_o | output | 1 | Interrupt, active low |
| ts_out_en_o | output | 2 | Stream output enables |
| tuner_rst_n_o | output | 2 | Tuner resets, active low |

## Verification
The bench first targets the address split. It writes a 1 into address bit 0 and checks that the card sees an even byte address, so a design that stored the raw low byte would shift the card address by one. It then writes the data register a second time while a strobe is still running. A design that restarted the cycle would lengthen the strobe or change the write data in flight. It also writes 0 into a reset bit while that reset is running, which would cut the reset short if zeros were honoured. Finally, it toggles a card-detect input whose interrupt enable is cleared, and then one whose enable is set. A design that swapped the slot-to-enable mapping would raise the interrupt on the wrong slot.

// File: rtl/ca_pkg.sv
package ca_pkg;
  localparam logic [3:0] REG_INT  = 4'h0;
  localparam logic [3:0] REG_BC2  = 4'h1;
  localparam logic [3:0] REG_ALO  = 4'h4;
  localparam logic [3:0] REG_AHI  = 4'h5;
  localparam logic [3:0] REG_DATA = 4'h6;
  localparam logic [3:0] REG_BC   = 4'h7;
  localparam int SLOTS   = 2;
  localparam int CADDR_W = 14;

  typedef struct packed {
    logic               slot;
    logic               iosp;
    logic [CADDR_W-1:0] addr;
  } cyc_req_t;
endpackage

// File: rtl/ca_sync.sv
module ca_sync #(
  parameter int           W    = 2,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= INIT;
      s2_q <= INIT;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/ca_rst_timer.sv
module ca_rst_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end
  assign busy_o = busy_q;

  a_r6_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  a_r6_no_early_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q != LAST) |=> busy_o);
endmodule

// File: rtl/ca_card_cycle.sv
module ca_card_cycle
  import ca_pkg::*;
#(
  parameter int STROBE_CYCLES = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     rd_i,
  input  cyc_req_t req_i,
  input  logic [7:0] wdata_i,
  input  logic [7:0] card_rdata_i,
  output cyc_req_t req_o,
  output logic [7:0] wdata_o,
  output logic     busy_o,
  output logic     rd_strobe_o,
  output logic     wr_strobe_o,
  output logic     done_o,
  output logic [7:0] rdata_o
);
  localparam int SW = (STROBE_CYCLES < 2) ? 1 : $clog2(STROBE_CYCLES + 1);
  localparam logic [SW-1:0] LAST = SW'(STROBE_CYCLES - 1);

  logic [SW-1:0] cnt_q;
  logic          busy_q, rd_q, done_q;
  cyc_req_t      req_q;
  logic [7:0]    wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      req_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q  <= 1'b1;
        rd_q    <= rd_i;
        cnt_q   <= '0;
        req_q   <= req_i;
        if (!rd_i) wdata_q <= wdata_i;
      end else if (busy_q) begin
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= rd_q;
          if (rd_q) rdata_q <= card_rdata_i;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign rd_strobe_o = busy_q & rd_q;
  assign wr_strobe_o = busy_q & ~rd_q;
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;
  assign req_o       = req_q;
  assign wdata_o     = wdata_q;

  a_r4_done_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(rd_strobe_o));
  a_r11_wdata_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(wdata_o));
endmodule

// File: rtl/ca_slot_ctrl.sv
module ca_slot_ctrl
  import ca_pkg::*;
#(
  parameter int STROBE_CYCLES = 4,
  parameter int RST_CYCLES    = 1000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [3:0]  reg_addr_i,
  input  logic [7:0]  reg_wdata_i,
  input  logic        reg_we_i,
  input  logic        reg_re_i,
  output logic [7:0]  reg_rdata_o,
  output logic        reg_rvalid_o,
  output logic        cyc_busy_o,
  output logic [14:0] card_addr_o,
  output logic [1:0]  card_sel_o,
  output logic        card_iosp_o,
  output logic        card_rd_o,
  output logic        card_wr_o,
  output logic [7:0]  card_wdata_o,
  input  logic [7:0]  card_rdata_i,
  output logic [1:0]  card_rst_o,
  input  logic [1:0]  card_cd_n_i,
  output logic [1:0]  ts_en_o,
  output logic        irq_n_o,
  output logic [1:0]  ts_out_en_o,
  output logic [1:0]  tuner_rst_n_o
);
  // register state
  logic [7:1] alo_q;
  logic [6:0] ahi_q;
  logic       slot_q, iosp_q;
  logic [SLOTS-1:0] ts_q;
  logic [7:0] bc2_q;
  logic [7:1] ien_q;
  logic       pend_q;
  logic [7:0] rd_q;
  logic       rv_q;

  logic wr_hit_bc, rd_hit_int, data_acc;
  assign wr_hit_bc  = reg_we_i && reg_addr_i == REG_BC;
  assign rd_hit_int = reg_re_i && reg_addr_i == REG_INT;
  assign data_acc   = (reg_we_i || reg_re_i) && reg_addr_i == REG_DATA;

  // card detect and interrupt
  logic [SLOTS-1:0] cd_s, cd_prev_q, cd_chg;
  logic             int_hit;

  ca_sync #(.W(SLOTS), .INIT({SLOTS{1'b1}})) u_cd_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(card_cd_n_i), .q_o(cd_s)
  );

  assign cd_chg  = cd_s ^ cd_prev_q;
  assign int_hit = (cd_chg[0] & ien_q[6]) | (cd_chg[1] & ien_q[2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cd_prev_q <= '1;
      pend_q    <= 1'b0;
    end else begin
      cd_prev_q <= cd_s;
      if (int_hit)         pend_q <= 1'b1;
      else if (rd_hit_int) pend_q <= 1'b0;
    end
  end
  assign irq_n_o = ~pend_q;

  // slot resets
  logic [SLOTS-1:0] rst_start, rst_busy;
  assign rst_start[0] = wr_hit_bc & reg_wdata_i[5];
  assign rst_start[1] = wr_hit_bc & reg_wdata_i[4];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot_rst
    ca_rst_timer #(.CYCLES(RST_CYCLES)) u_rst (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(rst_start[s]),
      .busy_o (rst_busy[s])
    );
  end
  assign card_rst_o = rst_busy;

  // card cycle engine
  cyc_req_t   req_new, req_cur;
  logic       cyc_busy, cyc_rd, cyc_wr, cyc_done;
  logic [7:0] cyc_rdata;

  assign req_new = '{slot: slot_q, iosp: iosp_q, addr: {ahi_q, alo_q}};

  ca_card_cycle #(.STROBE_CYCLES(STROBE_CYCLES)) u_cyc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (data_acc),
    .rd_i        (reg_re_i),
    .req_i       (req_new),
    .wdata_i     (reg_wdata_i),
    .card_rdata_i(card_rdata_i),
    .req_o       (req_cur),
    .wdata_o     (card_wdata_o),
    .busy_o      (cyc_busy),
    .rd_strobe_o (cyc_rd),
    .wr_strobe_o (cyc_wr),
    .done_o      (cyc_done),
    .rdata_o     (cyc_rdata)
  );

  assign cyc_busy_o  = cyc_busy;
  assign card_rd_o   = cyc_rd;
  assign card_wr_o   = cyc_wr;
  assign card_addr_o = {req_cur.addr, 1'b0};
  assign card_iosp_o = req_cur.iosp;
  assign card_sel_o  = (cyc_rd | cyc_wr) ? (req_cur.slot ? 2'b10 : 2'b01) : 2'b00;

  // register writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alo_q  <= '0;
      ahi_q  <= '0;
      slot_q <= 1'b0;
      iosp_q <= 1'b0;
      ts_q   <= '0;
      bc2_q  <= 8'h0C;
      ien_q  <= '0;
    end else if (reg_we_i) begin
      unique case (reg_addr_i)
        REG_ALO: alo_q <= reg_wdata_i[7:1];
        REG_AHI: ahi_q <= reg_wdata_i[6:0];
        REG_BC: begin
          slot_q <= reg_wdata_i[7];
          iosp_q <= reg_wdata_i[6];
          ts_q   <= {reg_wdata_i[2], reg_wdata_i[3]};
        end
        REG_BC2: bc2_q <= reg_wdata_i;
        REG_INT: ien_q <= reg_wdata_i[7:1];
        default: ;
      endcase
    end
  end

  assign ts_en_o       = ts_q;
  assign ts_out_en_o   = bc2_q[5:4];
  assign tuner_rst_n_o = {bc2_q[2], bc2_q[3]};

  // register reads
  logic [7:0] rd_mux;
  always_comb begin
    unique case (reg_addr_i)
      REG_INT: rd_mux = {ien_q, pend_q};
      REG_BC2: rd_mux = bc2_q;
      REG_ALO: rd_mux = {alo_q, 1'b0};
      REG_AHI: rd_mux = {1'b0, ahi_q};
      REG_BC:  rd_mux = {slot_q, iosp_q, rst_busy[0], rst_busy[1],
                         ts_q[0], ts_q[1], cd_s[0], cd_s[1]};
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
      rv_q <= 1'b0;
    end else begin
      rv_q <= reg_re_i && reg_addr_i != REG_DATA;
      if (reg_re_i) rd_q <= rd_mux;
    end
  end

  assign reg_rvalid_o = rv_q | cyc_done;
  assign reg_rdata_o  = cyc_done ? cyc_rdata : rd_q;

  a_r2_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_rd_o || card_wr_o) |-> $onehot(card_sel_o));
  a_r2_sel_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(card_rd_o || card_wr_o) |-> card_sel_o == 2'b00);
  a_r11_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_busy_o && $past(cyc_busy_o)) |-> $stable(card_addr_o));
  a_r9_irq_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_hit |=> !irq_n_o);
  a_r9_irq_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit_int && !int_hit) |=> irq_n_o);
  a_r3_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({card_rd_o, card_wr_o}));
endmodule

// File: tb/ca_slot_ctrl_tb.sv
module ca_slot_ctrl_tb;
  localparam int STROBE = 4;
  localparam int RSTC   = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0]  reg_rdata;
  logic        reg_rvalid, cyc_busy;
  logic [14:0] card_addr;
  logic [1:0]  card_sel, card_rst, ts_en, ts_out_en, tuner_rst_n;
  logic        card_iosp, card_rd, card_wr, irq_n;
  logic [7:0]  card_wdata, card_rdata;
  logic [1:0]  cd_n = 2'b11;

  always #10 clk = ~clk;

  ca_slot_ctrl #(.STROBE_CYCLES(STROBE), .RST_CYCLES(RSTC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_we_i(reg_we), .reg_re_i(reg_re),
    .reg_rdata_o(reg_rdata), .reg_rvalid_o(reg_rvalid), .cyc_busy_o(cyc_busy),
    .card_addr_o(card_addr), .card_sel_o(card_sel), .card_iosp_o(card_iosp),
    .card_rd_o(card_rd), .card_wr_o(card_wr), .card_wdata_o(card_wdata),
    .card_rdata_i(card_rdata), .card_rst_o(card_rst), .card_cd_n_i(cd_n),
    .ts_en_o(ts_en), .irq_n_o(irq_n), .ts_out_en_o(ts_out_en), .tuner_rst_n_o(tuner_rst_n)
  );

  function automatic logic [7:0] card_model(logic [14:0] ba, logic slot, logic iosp);
    return ba[7:0] ^ {1'b0, ba[14:8]} ^ {slot, iosp, 6'b0};
  endfunction

  assign card_rdata = card_rd ? card_model(card_addr, card_sel[1], card_iosp) : 8'h00;

  int n_chk = 0, n_fail = 0, mon_cnt = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each read response
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      if (exp_q.size() == 0) chk(1'b0, "unexpected rvalid", reg_rdata, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(reg_rdata == e, t, reg_rdata, e);
      end
      mon_cnt++;
    end
  end

  // background strobe / reset observers
  int wr_cnt = 0, rd_cnt = 0, rst0_cnt = 0, rst1_cnt = 0;
  logic [7:0]  last_wdata;
  logic [14:0] last_addr;
  logic [1:0]  last_sel;
  logic        last_iosp;
  always @(negedge clk) begin
    if (card_wr) wr_cnt++;
    if (card_rd) rd_cnt++;
    if (card_rst[0]) rst0_cnt++;
    if (card_rst[1]) rst1_cnt++;
    if (card_wr || card_rd) begin
      last_wdata = card_wdata;
      last_addr  = card_addr;
      last_sel   = card_sel;
      last_iosp  = card_iosp;
    end
  end

  task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, input logic [7:0] e, input string t);
    int start;
    exp_q.push_back(e);
    tag_q.push_back(t);
    start = mon_cnt;
    @(negedge clk);
    reg_addr = a; reg_re = 1'b1;
    @(negedge clk);
    reg_re = 1'b0;
    for (int i = 0; i < 100 && mon_cnt == start; i++) @(negedge clk);
    if (mon_cnt == start) chk(1'b0, {t, " no response"}, 0, e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  localparam logic [13:0] A = 14'h2A5B;

  initial begin
    int w0, r0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R12 reset state
    chk(irq_n == 1'b1, "R12 irq_n", irq_n, 1);
    chk(tuner_rst_n == 2'b11, "R12 tuner_rst_n", tuner_rst_n, 3);
    chk({card_rd, card_wr, card_rst, ts_en, ts_out_en} == '0, "R12 outputs idle",
        {card_rd, card_wr, card_rst, ts_en, ts_out_en}, 0);
    reg_rd(4'h1, 8'h0C, "R10 bc2 reset value");
    reg_rd(4'h7, 8'h03, "R8 bc no cards");

    // R1 address split, bit 0 forced low
    reg_wr(4'h4, 8'((A << 1) & 14'h00FE) | 8'h01);
    reg_wr(4'h5, 8'((A >> 7) & 14'h7F) | 8'h80);
    reg_rd(4'h4, 8'((A << 1) & 14'h00FE), "R1 addr low readback");
    reg_rd(4'h5, 8'((A >> 7) & 14'h7F), "R5 R1 addr high readback");

    // R3 write cycle, slot 0, IO space
    reg_wr(4'h7, 8'h40);
    w0 = wr_cnt;
    reg_wr(4'h6, 8'h5A);
    idle(STROBE + 3);
    chk(wr_cnt - w0 == STROBE, "R3 write strobe length", wr_cnt - w0, STROBE);
    chk(last_wdata == 8'h5A, "R3 write data", last_wdata, 8'h5A);
    chk(last_addr == {A, 1'b0}, "R1 card address", last_addr, {A, 1'b0});
    chk(last_sel == 2'b01, "R2 slot 0 select", last_sel, 1);
    chk(last_iosp == 1'b1, "R2 io space", last_iosp, 1);
    chk(card_sel == 2'b00, "R2 select idle", card_sel, 0);

    // R4 read cycle, slot 1, attribute memory
    reg_wr(4'h7, 8'h80);
    r0 = rd_cnt;
    reg_rd(4'h6, card_model({A, 1'b0}, 1'b1, 1'b0), "R4 card read data");
    chk(rd_cnt - r0 == STROBE, "R4 read strobe length", rd_cnt - r0, STROBE);
    chk(last_sel == 2'b10, "R2 slot 1 select", last_sel, 2);
    chk(last_iosp == 1'b0, "R2 attribute space", last_iosp, 0);

    // R11 second data write during busy is ignored
    w0 = wr_cnt;
    @(negedge clk);
    reg_addr = 4'h6; reg_wdata = 8'h11; reg_we = 1'b1;
    @(negedge clk);
    chk(cyc_busy == 1'b1, "R11 busy flag", cyc_busy, 1);
    reg_wdata = 8'h22;
    @(negedge clk);
    reg_we = 1'b0;
    idle(STROBE + 3);
    chk(wr_cnt - w0 == STROBE, "R11 strobe not extended", wr_cnt - w0, STROBE);
    chk(last_wdata == 8'h11, "R11 write data kept", last_wdata, 8'h11);

    // R7 stream routing bits; R8 detect bits ignore writes
    reg_wr(4'h7, 8'h0C);
    chk(ts_en == 2'b11, "R7 both routes", ts_en, 3);
    reg_wr(4'h7, 8'h08 | 8'h00);
    chk(ts_en == 2'b01, "R7 slot 0 route", ts_en, 1);
    cd_n = 2'b10;
    idle(5);
    chk(irq_n == 1'b1, "R9 disabled no irq", irq_n, 1);
    reg_wr(4'h7, 8'h0B);
    reg_rd(4'h7, 8'h09, "R8 detect readback");

    // R9 interrupt on slot 1 change
    reg_wr(4'h0, 8'h44);
    cd_n = 2'b00;
    idle(5);
    chk(irq_n == 1'b0, "R9 irq asserted", irq_n, 0);
    reg_rd(4'h0, 8'h45, "R9 pending read");
    chk(irq_n == 1'b1, "R9 irq acked", irq_n, 1);
    reg_rd(4'h0, 8'h44, "R9 pending cleared");
    // only slot 0 enabled
    reg_wr(4'h0, 8'h40);
    cd_n = 2'b10;
    idle(5);
    chk(irq_n == 1'b1, "R9 slot 1 masked", irq_n, 1);
    cd_n = 2'b11;
    idle(5);
    chk(irq_n == 1'b0, "R9 slot 0 change", irq_n, 0);
    reg_rd(4'h0, 8'h41, "R9 slot 0 pending");

    // R6 slot resets
    rst0_cnt = 0;
    reg_wr(4'h7, 8'h28);
    chk(card_rst == 2'b01, "R6 slot 0 reset active", card_rst, 1);
    reg_rd(4'h7, 8'h2B, "R6 busy bit set");
    reg_wr(4'h7, 8'h08);
    chk(card_rst[0] == 1'b1, "R6 zero write ignored", card_rst[0], 1);
    for (int i = 0; i < 3000 && card_rst[0]; i++) @(negedge clk);
    chk(rst0_cnt == RSTC, "R6 slot 0 reset length", rst0_cnt, RSTC);
    reg_rd(4'h7, 8'h0B, "R6 busy bit cleared");
    rst1_cnt = 0;
    reg_wr(4'h7, 8'h18);
    chk(card_rst == 2'b10, "R6 slot 1 reset active", card_rst, 2);
    for (int i = 0; i < 3000 && card_rst[1]; i++) @(negedge clk);
    chk(rst1_cnt == RSTC, "R6 slot 1 reset length", rst1_cnt, RSTC);

    // R10 bus-control-2 outputs
    reg_wr(4'h1, 8'h34);
    chk(ts_out_en == 2'b11, "R10 stream outputs", ts_out_en, 3);
    chk(tuner_rst_n == 2'b10, "R10 tuner 0 in reset", tuner_rst_n, 2);
    reg_wr(4'h1, 8'h08);
    chk(tuner_rst_n == 2'b01, "R10 tuner 1 in reset", tuner_rst_n, 1);
    reg_rd(4'h1, 8'h08, "R10 bc2 readback");

    idle(3);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule